// File: doc/BRIEF.md
# Triggered Transfer Sequencer

This block is the per-channel sequencer of a peripheral DMA. Each trigger pulse from a peripheral starts a run of element writes toward the data side. The number of writes in the run comes from a static element count. Each write carries a byte count taken from the static element size. A 32-bit access mode can force that byte count to four when the data port is four bytes wide.

Each completed run of writes is one FIFO operation. The block counts these operations against a static per-packet limit. On the last beat of the operation that reaches the limit, it raises a boundary marker. The marker is end-of-packet by default, or end-of-line when the line select is set. A limit of zero turns delineation off, so framing is left to upstream control. This is how a transmit channel is set up.

Triggers that arrive while a run is still issuing are queued and served back to back, with no lost trigger. Writes move only in cycles where the data side signals ready. A synchronous channel clear returns the channel to idle.

Top module: `trig_xfer_seq`

## Requirements
- R1: After reset, and in the cycle after `sync_clr` is sampled high, `wr_valid`, `wr_eop` and `wr_eol` are low. A `trig` sampled together with `sync_clr` is dropped.
- R2: Each accepted trigger produces exactly `cfg_elem_cnt` accepted writes. A write is accepted in a cycle with `wr_valid` and `wr_ready` both high.
- R3: Once `wr_valid` is high it stays high until the pending write is accepted. The element position advances only on an accepted write.
- R4: `wr_bytes` equals `cfg_elem_bytes` when `cfg_acc32` is low. When the data port is not 4 bytes wide, `wr_bytes` equals `cfg_elem_bytes` whatever `cfg_acc32` is.
- R5: With `cfg_acc32` high and a 4-byte data port, `wr_bytes` is 4 on every write.
- R6: With `cfg_fifo_cnt` = N > 0 and `cfg_eol` low, the last write of every N-th completed run carries `wr_eop`.
- R7: With `cfg_eol` high, that same beat carries `wr_eol` instead, and `wr_eop` stays low.
- R8: With `cfg_fifo_cnt` = 0, neither `wr_eop` nor `wr_eol` is ever raised. A transmit channel holds this value.
- R9: A trigger that arrives while a run is in progress is queued. Queued runs start with no idle cycle between them, so k triggers give k·`cfg_elem_cnt` writes on consecutive ready cycles.
- R10: The completed-run count returns to zero after each marker and on `sync_clr`. After a clear, the next marker comes N fresh runs later.
- R11: A trigger sampled while `cfg_elem_cnt` is 0 is ignored. It issues no write, and no write appears after the count is later made non-zero.
- R12: A marker is raised only together with `wr_valid`, on the final write of a run. `wr_eop` and `wr_eol` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous channel clear |
| trig | input | 1 | Peripheral trigger pulse |
| cfg_elem_bytes | input | BYTE_W | Bytes per element |
| cfg_elem_cnt | input | ECNT_W | Elements per trigger |
| cfg_fifo_cnt | input | FCNT_W | Runs per packet, 0 = no delineation |
| cfg_eol | input | 1 | Marker kind: 1 = end-of-line, 0 = end-of-packet |
| cfg_acc32 | input | 1 | Force 4-byte accesses on a 4-byte port |
| wr_ready | input | 1 | Data side can accept a write |
| wr_valid | output | 1 | Write strobe |
| wr_bytes | output | BYTE_W | Byte count of the current write |
| wr_eop | output | 1 | End-of-packet on this beat |
| wr_eol | output | 1 | End-of-line on this beat |

## Verification
Single triggers with ready held high set the run length against the element count. A ready pattern with stalls shows whether the strobe holds and whether the position moves on anything other than an accepted beat. Triggers fired on consecutive cycles, and triggers fired during a long stall, tell a queue apart from a one-deep latch and show any bubble between runs. Runs of triggers under packet limits of three and zero, with each line select, locate the beat that carries the marker and show which marker appears. A clear issued partway through a packet shows whether the run count restarts.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [1:0] {
    MARK_NONE = 2'd0,
    MARK_EOP  = 2'd1,
    MARK_EOL  = 2'd2
  } mark_e;

  function automatic logic port_is_32b(input int unsigned port_bytes);
    return port_bytes == 4;
  endfunction

endpackage

// File: rtl/xfer_trig_queue.sv
module xfer_trig_queue #(
  parameter int unsigned PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic trig_v,
  input  logic seq_done,
  output logic busy,
  output logic start
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              busy_q, busy_d;
  logic              start_ok, have_pend, reg_en;

  assign start_ok  = !busy_q || seq_done;
  assign have_pend = (pend_q != '0);
  assign reg_en    = sync_clr || trig_v || start_ok;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    start  = 1'b0;
    if (sync_clr) begin
      pend_d = '0;
      busy_d = 1'b0;
    end else if (start_ok) begin
      if (have_pend) begin
        start  = 1'b1;
        busy_d = 1'b1;
        pend_d = trig_v ? pend_q : (pend_q - PEND_ONE);
      end else if (trig_v) begin
        start  = 1'b1;
        busy_d = 1'b1;
      end else begin
        busy_d = 1'b0;
      end
    end else if (trig_v) begin
      pend_d = pend_q + PEND_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= 1'b0;
    end else if (reg_en) begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R9: queue depth must never wrap
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q == PEND_MAX && trig_v && !start_ok && !sync_clr));

  // R1: a clear leaves the channel idle
  a_r1_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> !busy_q);

  // R3: an unaccepted run keeps the strobe up
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !seq_done && !sync_clr) |=> busy_q);

endmodule

// File: rtl/xfer_elem_counter.sv
module xfer_elem_counter #(
  parameter int unsigned ECNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              start,
  input  logic              accept,
  input  logic [ECNT_W-1:0] cfg_elem_cnt,
  output logic              last_elem
);

  localparam logic [ECNT_W-1:0] ONE = ECNT_W'(1);

  logic [ECNT_W-1:0] idx_q, idx_d;
  logic              idx_en;

  assign last_elem = (idx_q == (cfg_elem_cnt - ONE));
  assign idx_en    = sync_clr || start || accept;

  always_comb begin
    idx_d = idx_q;
    if (sync_clr || start || (accept && last_elem))
      idx_d = '0;
    else if (accept)
      idx_d = idx_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_en)
      idx_q <= idx_d;
  end

  // R2: the element position stays inside the run
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (idx_q < cfg_elem_cnt));

endmodule

// File: rtl/xfer_pkt_counter.sv
module xfer_pkt_counter
  import xfer_seq_pkg::*;
#(
  parameter int unsigned FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              beat_last,
  input  logic              seq_done,
  input  logic [FCNT_W-1:0] cfg_fifo_cnt,
  input  logic              cfg_eol,
  output mark_e             mark
);

  localparam logic [FCNT_W-1:0] ONE = FCNT_W'(1);

  logic [FCNT_W-1:0] op_q, op_d;
  logic              delineate, last_op, op_en;

  assign delineate = (cfg_fifo_cnt != '0);
  assign last_op   = delineate && (op_q == (cfg_fifo_cnt - ONE));
  assign op_en     = sync_clr || seq_done;

  always_comb begin
    mark = MARK_NONE;
    if (beat_last && last_op)
      mark = cfg_eol ? MARK_EOL : MARK_EOP;
  end

  always_comb begin
    op_d = op_q;
    if (sync_clr || (seq_done && (last_op || !delineate)))
      op_d = '0;
    else if (seq_done)
      op_d = op_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      op_q <= '0;
    else if (op_en)
      op_q <= op_d;
  end

  // R10: run count stays below the packet limit
  a_r10_op_bound: assert property (@(posedge clk) disable iff (!rst_n)
    delineate |-> (op_q < cfg_fifo_cnt));

  // R10: count restarts after the closing run
  a_r10_op_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && last_op && !sync_clr) |=> (op_q == '0));

endmodule

// File: rtl/xfer_acc_width.sv
module xfer_acc_width
  import xfer_seq_pkg::*;
#(
  parameter int unsigned PORT_BYTES = 4,
  parameter int unsigned BYTE_W     = 4
) (
  input  logic [BYTE_W-1:0] cfg_elem_bytes,
  input  logic              cfg_acc32,
  output logic [BYTE_W-1:0] wr_bytes
);

  localparam logic [BYTE_W-1:0] FOUR = BYTE_W'(4);

  generate
    if (port_is_32b(PORT_BYTES)) begin : g_port32
      assign wr_bytes = cfg_acc32 ? FOUR : cfg_elem_bytes;
    end else begin : g_portx
      logic unused_acc32;
      assign unused_acc32 = cfg_acc32;
      assign wr_bytes     = cfg_elem_bytes;
    end
  endgenerate

endmodule

// File: rtl/trig_xfer_seq.sv
module trig_xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int unsigned PORT_BYTES = 4,
  parameter int unsigned BYTE_W     = 4,
  parameter int unsigned ECNT_W     = 8,
  parameter int unsigned FCNT_W     = 8,
  parameter int unsigned PEND_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              trig,
  input  logic [BYTE_W-1:0] cfg_elem_bytes,
  input  logic [ECNT_W-1:0] cfg_elem_cnt,
  input  logic [FCNT_W-1:0] cfg_fifo_cnt,
  input  logic              cfg_eol,
  input  logic              cfg_acc32,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_bytes,
  output logic              wr_eop,
  output logic              wr_eol
);

  logic  trig_v, busy, start, accept, last_elem, seq_done, beat_last;
  mark_e mark;

  assign trig_v    = trig && (cfg_elem_cnt != '0);
  assign accept    = busy && wr_ready;
  assign seq_done  = accept && last_elem;
  assign beat_last = busy && last_elem;

  xfer_trig_queue #(.PEND_W(PEND_W)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_clr (sync_clr),
    .trig_v   (trig_v),
    .seq_done (seq_done),
    .busy     (busy),
    .start    (start)
  );

  xfer_elem_counter #(.ECNT_W(ECNT_W)) u_elem (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_clr     (sync_clr),
    .start        (start),
    .accept       (accept),
    .cfg_elem_cnt (cfg_elem_cnt),
    .last_elem    (last_elem)
  );

  xfer_pkt_counter #(.FCNT_W(FCNT_W)) u_pkt (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_clr     (sync_clr),
    .beat_last    (beat_last),
    .seq_done     (seq_done),
    .cfg_fifo_cnt (cfg_fifo_cnt),
    .cfg_eol      (cfg_eol),
    .mark         (mark)
  );

  xfer_acc_width #(.PORT_BYTES(PORT_BYTES), .BYTE_W(BYTE_W)) u_width (
    .cfg_elem_bytes (cfg_elem_bytes),
    .cfg_acc32      (cfg_acc32),
    .wr_bytes       (wr_bytes)
  );

  assign wr_valid = busy;
  assign wr_eop   = (mark == MARK_EOP);
  assign wr_eol   = (mark == MARK_EOL);

  // R12: a marker rides only on a strobed beat
  a_r12_mark_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eop || wr_eol) |-> wr_valid);

  // R12: the two markers exclude each other
  a_r12_one_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_eop && wr_eol));

endmodule

// File: tb/trig_xfer_seq_test.sv
`timescale 1ns/1ps
module trig_xfer_seq_test;

  localparam int BYTE_W = 4;
  localparam int ECNT_W = 8;
  localparam int FCNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, sync_clr, trig, cfg_eol, cfg_acc32, wr_ready;
  logic [BYTE_W-1:0] cfg_elem_bytes;
  logic [ECNT_W-1:0] cfg_elem_cnt;
  logic [FCNT_W-1:0] cfg_fifo_cnt;
  logic wr_valid, wr_eop, wr_eol;
  logic [BYTE_W-1:0] wr_bytes;
  logic w_valid, w_eop, w_eol;
  logic [BYTE_W-1:0] w_bytes;

  always #10 clk = ~clk;

  trig_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .trig(trig),
    .cfg_elem_bytes(cfg_elem_bytes), .cfg_elem_cnt(cfg_elem_cnt),
    .cfg_fifo_cnt(cfg_fifo_cnt), .cfg_eol(cfg_eol), .cfg_acc32(cfg_acc32),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_bytes(wr_bytes),
    .wr_eop(wr_eop), .wr_eol(wr_eol));

  trig_xfer_seq #(.PORT_BYTES(8)) uut_wide (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .trig(trig),
    .cfg_elem_bytes(cfg_elem_bytes), .cfg_elem_cnt(cfg_elem_cnt),
    .cfg_fifo_cnt(cfg_fifo_cnt), .cfg_eol(cfg_eol), .cfg_acc32(cfg_acc32),
    .wr_ready(wr_ready), .wr_valid(w_valid), .wr_bytes(w_bytes),
    .wr_eop(w_eop), .wr_eol(w_eol));

  int tests_run = 0;
  int tests_failed = 0;

  // monitor state, sampled at the falling edge
  int cyc = 0, beats = 0, eop_cnt = 0, eol_cnt = 0, last_mark_beat = 0;
  int first_beat_cyc = -1, last_beat_cyc = -1;
  int byte_err = 0, stall_err = 0, mark_err = 0;
  int exp_bytes = 0;
  bit prev_stall = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall && !wr_valid) stall_err++;
      prev_stall = wr_valid && !wr_ready && !sync_clr;
      if ((wr_eop || wr_eol) && !wr_valid) mark_err++;
      if (wr_eop && wr_eol) mark_err++;
      if (wr_valid && wr_ready) begin
        beats++;
        if (first_beat_cyc < 0) first_beat_cyc = cyc;
        last_beat_cyc = cyc;
        if (int'(wr_bytes) != exp_bytes) byte_err++;
        if (wr_eop) begin eop_cnt++; last_mark_beat = beats; end
        if (wr_eol) begin eol_cnt++; last_mark_beat = beats; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    beats = 0; eop_cnt = 0; eol_cnt = 0; last_mark_beat = 0;
    first_beat_cyc = -1; last_beat_cyc = -1;
    byte_err = 0; stall_err = 0; mark_err = 0;
  endtask

  task automatic drv(input logic t, input logic r);
    @(posedge clk); #5;
    trig = t; wr_ready = r;
  endtask

  task automatic idle(input int n, input logic r);
    for (int i = 0; i < n; i++) drv(1'b0, r);
  endtask

  task automatic pulse_trig(input logic r);
    drv(1'b1, r);
    drv(1'b0, r);
  endtask

  task automatic setup(input int eb, input int ec, input int fc, input logic eol, input logic a32);
    @(posedge clk); #5;
    cfg_elem_bytes = BYTE_W'(eb); cfg_elem_cnt = ECNT_W'(ec);
    cfg_fifo_cnt = FCNT_W'(fc); cfg_eol = eol; cfg_acc32 = a32;
    clear_mon();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sync_clr = 1'b0; trig = 1'b0; wr_ready = 1'b1;
    cfg_elem_bytes = 4'd1; cfg_elem_cnt = 8'd1; cfg_fifo_cnt = 8'd0;
    cfg_eol = 1'b0; cfg_acc32 = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!wr_valid && !wr_eop && !wr_eol, "R1 reset outputs", int'(wr_valid), 0);
    @(posedge clk); #5; rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid, "R1 idle after reset", int'(wr_valid), 0);
  endtask

  task automatic t_basic();
    setup(3, 5, 0, 1'b0, 1'b0); exp_bytes = 3;
    pulse_trig(1'b1); idle(10, 1'b1);
    chk(beats == 5, "R2 writes per trigger", beats, 5);
    chk(byte_err == 0, "R4 element byte count", byte_err, 0);
    chk(eop_cnt + eol_cnt == 0, "R8 no marker with zero limit", eop_cnt + eol_cnt, 0);
  endtask

  task automatic t_stall();
    setup(2, 4, 0, 1'b0, 1'b0); exp_bytes = 2;
    pulse_trig(1'b0);
    for (int i = 0; i < 20; i++) drv(1'b0, (i % 3) == 2);
    idle(6, 1'b1);
    chk(beats == 4, "R3 writes under stalls", beats, 4);
    chk(stall_err == 0, "R3 strobe held while stalled", stall_err, 0);
  endtask

  task automatic t_acc32();
    setup(2, 3, 0, 1'b0, 1'b1); exp_bytes = 4;
    pulse_trig(1'b0);
    @(negedge clk);
    chk(wr_valid && int'(wr_bytes) == 4, "R5 forced four bytes", int'(wr_bytes), 4);
    chk(w_valid && int'(w_bytes) == 2, "R4 mode ignored on wide port", int'(w_bytes), 2);
    idle(8, 1'b1);
    chk(beats == 3 && byte_err == 0, "R5 every beat four bytes", byte_err, 0);
  endtask

  task automatic t_packet(input logic eol);
    setup(1, 2, 3, eol, 1'b0); exp_bytes = 1;
    for (int k = 0; k < 6; k++) begin
      pulse_trig(1'b1); idle(3, 1'b1);
    end
    if (!eol) begin
      chk(eop_cnt == 2, "R6 end-of-packet count", eop_cnt, 2);
      chk(eol_cnt == 0, "R6 no end-of-line", eol_cnt, 0);
    end else begin
      chk(eol_cnt == 2, "R7 end-of-line count", eol_cnt, 2);
      chk(eop_cnt == 0, "R7 end-of-packet suppressed", eop_cnt, 0);
    end
    chk(last_mark_beat == 12, "R12 marker on final beat", last_mark_beat, 12);
    chk(mark_err == 0, "R12 marker with strobe only", mark_err, 0);
  endtask

  task automatic t_back2back();
    setup(1, 3, 0, 1'b0, 1'b0); exp_bytes = 1;
    for (int k = 0; k < 4; k++) drv(1'b1, 1'b1);
    idle(16, 1'b1);
    chk(beats == 12, "R9 queued triggers served", beats, 12);
    chk(last_beat_cyc - first_beat_cyc + 1 == 12, "R9 no gap between runs",
        last_beat_cyc - first_beat_cyc + 1, 12);
  endtask

  task automatic t_pend_stall();
    setup(1, 2, 0, 1'b0, 1'b0); exp_bytes = 1;
    for (int k = 0; k < 3; k++) begin drv(1'b1, 1'b0); drv(1'b0, 1'b0); end
    idle(3, 1'b0);
    chk(beats == 0, "R3 nothing moves without ready", beats, 0);
    idle(10, 1'b1);
    chk(beats == 6, "R9 triggers during stall kept", beats, 6);
  endtask

  task automatic t_clear();
    setup(1, 2, 3, 1'b0, 1'b0); exp_bytes = 1;
    for (int k = 0; k < 2; k++) begin pulse_trig(1'b1); idle(3, 1'b1); end
    pulse_trig(1'b0); idle(2, 1'b0);
    @(negedge clk);
    chk(wr_valid, "R1 run stalled before clear", int'(wr_valid), 1);
    @(posedge clk); #5; sync_clr = 1'b1; trig = 1'b1;
    @(posedge clk); #5; sync_clr = 1'b0; trig = 1'b0;
    @(negedge clk);
    chk(!wr_valid, "R1 clear drops strobe", int'(wr_valid), 0);
    idle(3, 1'b1);
    chk(beats == 4, "R1 trigger with clear dropped", beats, 4);
    clear_mon();
    for (int k = 0; k < 2; k++) begin pulse_trig(1'b1); idle(3, 1'b1); end
    chk(eop_cnt == 0, "R10 count restarted by clear", eop_cnt, 0);
    pulse_trig(1'b1); idle(3, 1'b1);
    chk(eop_cnt == 1 && last_mark_beat == 6, "R10 marker after fresh runs", last_mark_beat, 6);
  endtask

  task automatic t_zero_cnt();
    setup(1, 0, 0, 1'b0, 1'b0); exp_bytes = 1;
    pulse_trig(1'b1); idle(3, 1'b1);
    chk(beats == 0 && !wr_valid, "R11 zero count issues nothing", beats, 0);
    @(posedge clk); #5; cfg_elem_cnt = 8'd2;
    idle(5, 1'b1);
    chk(beats == 0, "R11 ignored trigger not kept", beats, 0);
  endtask

  initial begin
    #(20 * 150000);
    tests_failed++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests_run + 1, tests_failed);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_stall();
    t_acc32();
    t_packet(1'b0);
    t_packet(1'b1);
    t_back2back();
    t_pend_stall();
    t_clear();
    t_zero_cnt();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule